// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This peripheral keeps time in whole seconds. A 32-bit elapsed-seconds up-counter and a paired down-counter both advance on a one-cycle tick strobe. The down-counter is meant to hold the ones' complement of the up-counter. Two compare registers are checked against the up-counter on every clock. When the count equals a compare value, a status bit is set. While equality holds, that bit is set again on every cycle, so clearing it only takes effect once the compare value or the count has moved on.

Software reaches the block over a plain 32-bit register bus. Writes are synchronous and reads are combinational. A control byte does five jobs:
- enables the interrupt for each compare;
- routes each compare's status to a level power-on request output;
- forces that output high;
- stops the counters so they can be loaded without a tick landing in the middle;
- holds both counters in a cleared state.

A free 32-bit marker register lets start-up code record that initialisation has already been done, so it does not set the block up a second time.

Top module: `sec_match_timer`

## Requirements
- R1: After reset the up-counter reads 0 and the down-counter reads 0xFFFFFFFF. Both compare registers read 0xFFFFFFFF. Control, status and the marker register read 0. The interrupt output and the power-on request output are low.
- R2: A tick with control bit 6 (stop) and bit 4 (hold-clear) both low does two things on the same clock edge: it adds 1 to the up-counter (offset 0x00) and subtracts 1 from the down-counter (offset 0x04). Without a tick neither counter changes.
- R3: While control bit 6 is set, ticks do not change either counter. Writes to 0x00 and 0x04 load those counters only while bit 6 is set. When bit 6 is clear, such writes are ignored.
- R4: While control bit 4 is set, the up-counter is held at 0 and the down-counter at 0xFFFFFFFF, and ticks have no effect. Counting resumes once the bit is cleared.
- R5: Compare k is at offset 0x08 for k=0 and 0x0C for k=1. Status bit k (status at 0x14) is set on the edge after any cycle in which the up-counter equals compare k. This happens whether or not counting is stopped.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the match still holds, it sets the bit again in the same cycle, and the set wins.
- R7: The interrupt output is high exactly when some status bit k (k=0,1) is set together with control bit k.
- R8: The power-on request output is high in three cases: control bit 7 is set; control bit 2 and status bit 0 are both set; or control bit 3 and status bit 1 are both set. Status bit 2 latches on the edge after either routed condition is active, is cleared by writing 1, and is not set by control bit 7.
- R9: The marker register at 0x18 stores any written 32-bit value and reads it back.
- R10: Offsets outside the seven listed read as 0, and writes to them change nothing. Control bit 5 and bits above 7 read as 0, so writing 0xFF to control reads back 0xDF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe, one per second |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request |
| pwr_req_o | output | 1 | Level power-on request |

## Verification
Every state register can be read back, so a corrupted count, compare value or status bit shows on bus_rdata on the very next read. A bad status bit also shows on irq_o or pwr_req_o in the same cycle as the bad state, provided the matching enable or route bit is set. A wrong stop or hold-clear decision only becomes visible after the next tick, so the directed sequences tick and then read back. Set-over-clear priority is exercised by clearing a status bit while its match still holds.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
   // register offsets (software-visible map)
   localparam logic [7:0] OFF_UP   = 8'h00;
   localparam logic [7:0] OFF_DN   = 8'h04;
   localparam logic [7:0] OFF_CMP0 = 8'h08;
   localparam logic [7:0] OFF_CTRL = 8'h10;
   localparam logic [7:0] OFF_STAT = 8'h14;
   localparam logic [7:0] OFF_MARK = 8'h18;
   localparam int         CMP_STRIDE = 4;
   localparam int         NUM_CMP    = 2;

   // control bit positions
   localparam int CB_IE0   = 0;
   localparam int CB_RT0   = 2;
   localparam int CB_HCLR  = 4;
   localparam int CB_STOP  = 6;
   localparam int CB_FORCE = 7;
   localparam logic [7:0] CTRL_MASK = 8'hDF;

   // status bit position of the power-request event
   localparam int SB_PWR = 2;
endpackage

// File: rtl/stm_cnt_pair.sv
module stm_cnt_pair #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         hold,
   input  logic         clear,
   input  logic         ld_up,
   input  logic         ld_dn,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] up_cnt,
   output logic [W-1:0] dn_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_cnt <= '0;
         dn_cnt <= '1;
      end else if (clear) begin
         up_cnt <= '0;
         dn_cnt <= '1;
      end else if (hold) begin
         if (ld_up) up_cnt <= wdata;
         if (ld_dn) dn_cnt <= wdata;
      end else if (tick) begin
         up_cnt <= up_cnt + 1'b1;
         dn_cnt <= dn_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/stm_match_slot.sv
module stm_match_slot #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic         wr_val,
   input  logic [W-1:0] wdata,
   input  logic         clr,
   output logic [W-1:0] val,
   output logic         hit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val <= '1;
      else if (wr_val) val <= wdata;
   end

   // set has priority over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else if (cnt == val) hit <= 1'b1;
      else if (clr) hit <= 1'b0;
   end
endmodule

// File: rtl/sec_match_timer.sv
module sec_match_timer
   import sec_timer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              pwr_req_o
);
   localparam int STAT_W = NUM_CMP + 1;

   if (DATA_W < 8) begin : g_bad_data
      $error("sec_match_timer: DATA_W must be at least 8");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("sec_match_timer: ADDR_W must reach offset 0x18");
   end

   logic                            sel_up, sel_dn, sel_ctrl, sel_stat, sel_mark;
   logic [NUM_CMP-1:0]              sel_cmp;
   logic [7:0]                      ctrl_q;
   logic [DATA_W-1:0]               mark_q;
   logic [DATA_W-1:0]               up_cnt, dn_cnt;
   logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_val;
   logic [NUM_CMP-1:0]              hit;
   logic [NUM_CMP-1:0]              ie_bits, rt_bits;
   logic                            pwr_src, pwr_stat;
   logic [STAT_W-1:0]               stat_q;

   assign sel_up   = bus_addr == ADDR_W'(OFF_UP);
   assign sel_dn   = bus_addr == ADDR_W'(OFF_DN);
   assign sel_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
   assign sel_stat = bus_addr == ADDR_W'(OFF_STAT);
   assign sel_mark = bus_addr == ADDR_W'(OFF_MARK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else if (bus_we && sel_ctrl) ctrl_q <= bus_wdata[7:0] & CTRL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mark_q <= '0;
      else if (bus_we && sel_mark) mark_q <= bus_wdata;
   end

   stm_cnt_pair #(.W(DATA_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_i),
      .hold   (ctrl_q[CB_STOP]),
      .clear  (ctrl_q[CB_HCLR]),
      .ld_up  (bus_we && sel_up),
      .ld_dn  (bus_we && sel_dn),
      .wdata  (bus_wdata),
      .up_cnt (up_cnt),
      .dn_cnt (dn_cnt)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      assign sel_cmp[i] = bus_addr == ADDR_W'(OFF_CMP0 + CMP_STRIDE * i);
      assign ie_bits[i] = ctrl_q[CB_IE0 + i];
      assign rt_bits[i] = ctrl_q[CB_RT0 + i];

      stm_match_slot #(.W(DATA_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .cnt    (up_cnt),
         .wr_val (bus_we && sel_cmp[i]),
         .wdata  (bus_wdata),
         .clr    (bus_we && sel_stat && bus_wdata[i]),
         .val    (cmp_val[i]),
         .hit    (hit[i])
      );
   end

   assign pwr_src = |(hit & rt_bits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_stat <= 1'b0;
      else if (pwr_src) pwr_stat <= 1'b1;
      else if (bus_we && sel_stat && bus_wdata[SB_PWR]) pwr_stat <= 1'b0;
   end

   assign stat_q    = {pwr_stat, hit};
   assign irq_o     = |(hit & ie_bits);
   assign pwr_req_o = ctrl_q[CB_FORCE] | pwr_src;

   always_comb begin
      bus_rdata = '0;
      if (sel_up)   bus_rdata = up_cnt;
      if (sel_dn)   bus_rdata = dn_cnt;
      if (sel_ctrl) bus_rdata = DATA_W'(ctrl_q);
      if (sel_stat) bus_rdata = DATA_W'(stat_q);
      if (sel_mark) bus_rdata = mark_q;
      for (int k = 0; k < NUM_CMP; k++)
         if (sel_cmp[k]) bus_rdata = cmp_val[k];
   end
endmodule

// File: rtl/sec_match_timer_chk.sv
module sec_match_timer_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick_i,
   input logic                   bus_we,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [DATA_W-1:0]      bus_rdata,
   input logic                   pwr_req_o,
   input logic [7:0]             ctrl_q,
   input logic [DATA_W-1:0]      up_cnt,
   input logic [DATA_W-1:0]      dn_cnt,
   input logic [1:0][DATA_W-1:0] cmp_val,
   input logic [2:0]             stat_q
);
   logic cnt_wr, mapped;
   assign cnt_wr = bus_we && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h04));
   assign mapped = bus_addr inside {ADDR_W'(8'h00), ADDR_W'(8'h04), ADDR_W'(8'h08),
                                    ADDR_W'(8'h0C), ADDR_W'(8'h10), ADDR_W'(8'h14),
                                    ADDR_W'(8'h18)};

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !ctrl_q[6] && !ctrl_q[4]) |=>
         (up_cnt == $past(up_cnt) + 1'b1) && (dn_cnt == $past(dn_cnt) - 1'b1));

   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[6] && !ctrl_q[4] && !cnt_wr) |=> ($stable(up_cnt) && $stable(dn_cnt)));

   // R4
   hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[4] |=> (up_cnt == '0 && dn_cnt == '1));

   // R5
   match0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == cmp_val[0]) |=> stat_q[0]);

   // R5
   match1_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt == cmp_val[1]) |=> stat_q[1]);

   // R8
   force_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[7] |-> pwr_req_o);

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0));
endmodule

bind sec_match_timer sec_match_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pwr_req_o (pwr_req_o),
   .ctrl_q    (ctrl_q),
   .up_cnt    (up_cnt),
   .dn_cnt    (dn_cnt),
   .cmp_val   (cmp_val),
   .stat_q    (stat_q)
);

// File: tb/sec_match_timer_bench.sv
module sec_match_timer_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, pwr_req_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sec_match_timer u_sec_match_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .pwr_req_o (pwr_req_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 check(req, bus_rdata, exp);
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 up", 8'h00, 32'h0);
      rd_chk("R1 down", 8'h04, 32'hFFFF_FFFF);
      rd_chk("R1 cmp0", 8'h08, 32'hFFFF_FFFF);
      rd_chk("R1 cmp1", 8'h0C, 32'hFFFF_FFFF);
      rd_chk("R1 ctrl", 8'h10, 32'h0);
      rd_chk("R1 stat", 8'h14, 32'h0);
      rd_chk("R1 mark", 8'h18, 32'h0);
      check("R1 irq", 32'(irq_o), 32'h0);
      check("R1 pwr", 32'(pwr_req_o), 32'h0);
   endtask

   task automatic t_count();
      for (int i = 0; i < 3; i++) pulse_tick();
      @(negedge clk); @(negedge clk);
      rd_chk("R2 up after 3 ticks", 8'h00, 32'd3);
      rd_chk("R2 down after 3 ticks", 8'h04, 32'hFFFF_FFFC);
   endtask

   task automatic t_stop();
      wr(8'h10, 32'h40);
      pulse_tick(); pulse_tick();
      rd_chk("R3 up frozen", 8'h00, 32'd3);
      wr(8'h00, 32'd100);
      wr(8'h04, ~32'd100);
      rd_chk("R3 up loaded", 8'h00, 32'd100);
      rd_chk("R3 down loaded", 8'h04, ~32'd100);
      wr(8'h10, 32'h0);
      wr(8'h00, 32'd5);
      wr(8'h04, 32'd0);
      rd_chk("R3 up load ignored while running", 8'h00, 32'd100);
      rd_chk("R3 down load ignored while running", 8'h04, ~32'd100);
      pulse_tick();
      rd_chk("R3 up resumes", 8'h00, 32'd101);
      rd_chk("R3 down resumes", 8'h04, ~32'd101);
   endtask

   task automatic t_hold_clear();
      wr(8'h10, 32'h10);
      rd_chk("R4 up cleared", 8'h00, 32'd0);
      pulse_tick();
      rd_chk("R4 up held", 8'h00, 32'd0);
      rd_chk("R4 down held", 8'h04, 32'hFFFF_FFFF);
      wr(8'h10, 32'h0);
      pulse_tick();
      rd_chk("R4 up counts after release", 8'h00, 32'd1);
      rd_chk("R4 down counts after release", 8'h04, 32'hFFFF_FFFE);
   endtask

   task automatic t_match();
      wr(8'h10, 32'h40);
      wr(8'h08, 32'd1);
      rd_chk("R5 cmp0 latch while stopped", 8'h14, 32'h1);
      check("R7 irq low when disabled", 32'(irq_o), 32'h0);
      wr(8'h14, 32'h1);
      rd_chk("R6 set wins while match holds", 8'h14, 32'h1);
      wr(8'h10, 32'h41);
      #1 check("R7 irq with enable", 32'(irq_o), 32'h1);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h14, 32'h2);
      rd_chk("R6 zero bit leaves status", 8'h14, 32'h1);
      wr(8'h14, 32'h1);
      rd_chk("R6 clear sticks", 8'h14, 32'h0);
      check("R7 irq drops", 32'(irq_o), 32'h0);
      wr(8'h10, 32'h0);
      wr(8'h0C, 32'd3);
      pulse_tick(); pulse_tick();
      rd_chk("R5 cmp1 latch while running", 8'h14, 32'h2);
      check("R7 irq low, bit1 disabled", 32'(irq_o), 32'h0);
   endtask

   task automatic t_pwr();
      check("R8 pwr low unrouted", 32'(pwr_req_o), 32'h0);
      wr(8'h10, 32'h08);
      #1 check("R8 pwr via route1", 32'(pwr_req_o), 32'h1);
      rd_chk("R8 pwr event latched", 8'h14, 32'h6);
      wr(8'h10, 32'h0);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h14, 32'h7);
      rd_chk("R8 status cleared", 8'h14, 32'h0);
      check("R8 pwr low after clear", 32'(pwr_req_o), 32'h0);
      wr(8'h10, 32'h80);
      #1 check("R8 force high", 32'(pwr_req_o), 32'h1);
      rd_chk("R8 force sets no event", 8'h14, 32'h0);
      wr(8'h10, 32'h0);
   endtask

   task automatic t_marker();
      wr(8'h18, 32'hB5C1_3F27);
      rd_chk("R9 marker value", 8'h18, 32'hB5C1_3F27);
      wr(8'h18, 32'h1234_5678);
      rd_chk("R9 arbitrary value", 8'h18, 32'h1234_5678);
   endtask

   task automatic t_unmapped();
      wr(8'h18, 32'hA5A5_A5A5);
      wr(8'h1C, 32'hDEAD_BEEF);
      wr(8'h40, 32'h0000_0000);
      rd_chk("R10 read 0x1C", 8'h1C, 32'h0);
      rd_chk("R10 read 0x40", 8'h40, 32'h0);
      rd_chk("R10 marker untouched", 8'h18, 32'hA5A5_A5A5);
      rd_chk("R10 up untouched", 8'h00, 32'd3);
      rd_chk("R10 cmp0 untouched", 8'h08, 32'hFFFF_FFFF);
      rd_chk("R10 ctrl untouched", 8'h10, 32'h0);
      wr(8'h10, 32'hFF);
      rd_chk("R10 ctrl unused bits", 8'h10, 32'hDF);
      wr(8'h10, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_stop();
      t_hold_clear();
      t_match();
      t_pwr();
      t_marker();
      t_unmapped();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule